// File: doc/BRIEF.md
# Packet FIFO with Per-Word Metadata and Status Window

This block is a single-clock, memory-mapped FIFO that carries packets as 32-bit words. Every stored entry pairs a data word with its own sideband word holding start/end-of-packet marks, a count of unused bytes, a channel number and an error code. A producer first writes the sideband for the coming word and then writes the data word, which pushes both as one entry. A consumer reads the data word, which pops the entry, and may then read the sideband of that same entry.

A second register window reports the fill level and the live flags: full, empty, almost-full and almost-empty. It also holds sticky events for those four flags and for overflow and underflow, an interrupt-enable mask and the two thresholds. One level-sensitive interrupt output is high while any enabled event is pending.

The bus is a simple single-cycle request port. `bus_win` = 0 selects the data window and `bus_win` = 1 selects the status window. Read data appears on `bus_rdata` in the cycle after the request.

Top module: `pkt_fifo_csr`

## Requirements
- R1: After reset the fill level is 0, the status word reads 0x0A (empty and almost-empty), and the event word, the enable mask and `irq` are all zero. The almost-full threshold resets to DEPTH-4 and the almost-empty threshold resets to 4.
- R2: A data-window write at offset 0x00 pushes the word together with the latched sideband. A data-window read at offset 0x00 returns the pushed words in arrival order, on `bus_rdata` one cycle after the request.
- R3: A data-window write at offset 0x04 latches a sideband word for the following pushes. After a data pop, a read of offset 0x04 returns the sideband of the popped entry. Sideband fields: bit 0 start-of-packet, bit 1 end-of-packet, bits 6:2 unused-byte count, bits 15:8 channel, bits 23:16 error code. Bits 7 and 31:24 always read 0.
- R4: The status-window offset 0x00 returns the fill level, which is pushes minus pops. Status word (offset 0x04) bit 0 (full) is set when the level equals DEPTH, and bit 1 (empty) is set when the level is 0.
- R5: Status bit 2 (almost-full) is set when the level is at or above the threshold at offset 0x10. Status bit 3 (almost-empty) is set when the level is at or below the threshold at offset 0x14. Both thresholds read back what was written.
- R6: A push while full is dropped, leaves the level at DEPTH and sets event bit 4 (overflow).
- R7: A pop while empty returns 0, leaves the level at 0 and sets event bit 5 (underflow).
- R8: Event bits (offset 0x08) use the same positions as the status bits. Bits 0 to 3 are set on a 0-to-1 transition of the matching status condition and stay set while the condition persists or falls.
- R9: Writing to offset 0x08 clears exactly the event bits written as 1. An event arriving in the same cycle wins over the clear.
- R10: `irq` is high exactly when some event bit is set whose enable bit, at offset 0x0C and in the same position, is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 0 = data window, 1 = status window |
| bus_addr | input | 5 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check the following: the level stays within bounds and moves by at most one per cycle; a push while full leaves the level at DEPTH and raises overflow; a pop while empty raises underflow; event bits never drop without a clear write; and the interrupt stays low when no enabled event is pending. Other behaviour is shown only by the bench's scenarios. This includes the ordering of data and sideband through a full fill and drain, the arithmetic of the threshold flags swept across every threshold value, edge-only capture of the level flags, and the selective clear.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam int BUS_W = 32;
    localparam int NFLAG = 6;

    // data window offsets
    localparam logic [4:0] OFF_DATA  = 5'h00;
    localparam logic [4:0] OFF_META  = 5'h04;
    // status window offsets
    localparam logic [4:0] OFF_LEVEL = 5'h00;
    localparam logic [4:0] OFF_STAT  = 5'h04;
    localparam logic [4:0] OFF_EVT   = 5'h08;
    localparam logic [4:0] OFF_IE    = 5'h0C;
    localparam logic [4:0] OFF_AFTH  = 5'h10;
    localparam logic [4:0] OFF_AETH  = 5'h14;

    typedef struct packed {
        logic [7:0] rsv_hi;
        logic [7:0] err;
        logic [7:0] chan;
        logic       rsv7;
        logic [4:0] empty_cnt;
        logic       eop;
        logic       sop;
    } meta_t;

    // bit 0 full ... bit 5 underflow
    typedef struct packed {
        logic underflow;
        logic overflow;
        logic aempty;
        logic afull;
        logic empty;
        logic full;
    } flags_t;

    function automatic meta_t meta_clean(logic [BUS_W-1:0] w);
        meta_t m;
        m        = meta_t'(w);
        m.rsv_hi = '0;
        m.rsv7   = 1'b0;
        return m;
    endfunction

    function automatic logic [BUS_W-1:0] flags_word(flags_t f);
        return {{(BUS_W-NFLAG){1'b0}}, f};
    endfunction

endpackage

// File: rtl/pfc_store.sv
module pfc_store
    import pfc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [BUS_W-1:0] wdata,
    input  meta_t            wmeta,
    output logic [BUS_W-1:0] rdata,
    output meta_t            rmeta,
    output logic [CW-1:0]    level
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [BUS_W-1:0] data_mem [DEPTH];
    meta_t            meta_mem [DEPTH];
    logic [PW-1:0]    wptr, rptr;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            data_mem[wptr] <= wdata;
            meta_mem[wptr] <= wmeta;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign rdata = data_mem[rptr];
    assign rmeta = meta_mem[rptr];

endmodule

// File: rtl/pfc_flags.sv
module pfc_flags
    import pfc_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int CW      = $clog2(DEPTH + 1),
    parameter int AF_INIT = DEPTH - 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] af_thr,
    input  logic [CW-1:0] ae_thr,
    input  logic          ovf_hit,
    input  logic          udf_hit,
    input  logic          clr_we,
    input  flags_t        clr_mask,
    input  flags_t        ie,
    output flags_t        status,
    output flags_t        events,
    output logic          irq
);
    // conditions as they stand right after reset (level 0)
    localparam flags_t PREV_INIT = '{underflow: 1'b0, overflow: 1'b0,
                                     aempty: 1'b1, afull: (AF_INIT == 0),
                                     empty: 1'b1, full: 1'b0};

    flags_t prev, rise, kill;

    always_comb begin
        status           = '0;
        status.full      = (level == CW'(DEPTH));
        status.empty     = (level == '0);
        status.afull     = (level >= af_thr);
        status.aempty    = (level <= ae_thr);

        rise             = status & ~prev;
        rise.overflow    = ovf_hit;
        rise.underflow   = udf_hit;

        kill             = clr_we ? clr_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= PREV_INIT;
            events <= '0;
        end else begin
            prev   <= status;
            events <= (events & ~kill) | rise;
        end
    end

    assign irq = |(events & ie);

endmodule

// File: rtl/pkt_fifo_csr.sv
module pkt_fifo_csr
    import pfc_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int AF_INIT = DEPTH - 4,
    parameter int AE_INIT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic             bus_win,
    input  logic [4:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0]    level, af_thr, ae_thr;
    logic [BUS_W-1:0] head_data;
    meta_t            head_meta, wr_meta, rd_meta;
    flags_t           st, ev, ie_q;
    logic [NFLAG-1:0] ev_bits, ie_bits;

    // access decode
    logic acc_dw, acc_dr, acc_mw, acc_mr, acc_cw, acc_cr;
    logic full_now, empty_now, push, pop;

    always_comb begin
        acc_dw    = bus_req &&  bus_we && !bus_win && bus_addr == OFF_DATA;
        acc_dr    = bus_req && !bus_we && !bus_win && bus_addr == OFF_DATA;
        acc_mw    = bus_req &&  bus_we && !bus_win && bus_addr == OFF_META;
        acc_mr    = bus_req && !bus_we && !bus_win && bus_addr == OFF_META;
        acc_cw    = bus_req &&  bus_we &&  bus_win;
        acc_cr    = bus_req && !bus_we &&  bus_win;
        full_now  = (level == CW'(DEPTH));
        empty_now = (level == '0);
        push      = acc_dw && !full_now;
        pop       = acc_dr && !empty_now;
    end

    pfc_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .wdata (bus_wdata),
        .wmeta (wr_meta),
        .rdata (head_data),
        .rmeta (head_meta),
        .level (level)
    );

    pfc_flags #(.DEPTH(DEPTH), .CW(CW), .AF_INIT(AF_INIT)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .level    (level),
        .af_thr   (af_thr),
        .ae_thr   (ae_thr),
        .ovf_hit  (acc_dw && full_now),
        .udf_hit  (acc_dr && empty_now),
        .clr_we   (acc_cw && bus_addr == OFF_EVT),
        .clr_mask (flags_t'(bus_wdata[NFLAG-1:0])),
        .ie       (ie_q),
        .status   (st),
        .events   (ev),
        .irq      (irq)
    );

    assign ev_bits = ev;
    assign ie_bits = ie_q;

    // writable registers
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_meta <= '0;
            ie_q    <= '0;
            af_thr  <= CW'(AF_INIT);
            ae_thr  <= CW'(AE_INIT);
        end else begin
            if (acc_mw) wr_meta <= meta_clean(bus_wdata);
            if (acc_cw) begin
                case (bus_addr)
                    OFF_IE:   ie_q   <= flags_t'(bus_wdata[NFLAG-1:0]);
                    OFF_AFTH: af_thr <= bus_wdata[CW-1:0];
                    OFF_AETH: ae_thr <= bus_wdata[CW-1:0];
                    default:  ;
                endcase
            end
        end
    end

    // read path, one cycle latency
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            rd_meta   <= '0;
        end else if (acc_dr) begin
            bus_rdata <= empty_now ? '0 : head_data;
            rd_meta   <= empty_now ? '0 : head_meta;
        end else if (acc_mr) begin
            bus_rdata <= rd_meta;
        end else if (acc_cr) begin
            case (bus_addr)
                OFF_LEVEL: bus_rdata <= {{(BUS_W-CW){1'b0}}, level};
                OFF_STAT:  bus_rdata <= flags_word(st);
                OFF_EVT:   bus_rdata <= flags_word(ev);
                OFF_IE:    bus_rdata <= flags_word(ie_q);
                OFF_AFTH:  bus_rdata <= {{(BUS_W-CW){1'b0}}, af_thr};
                OFF_AETH:  bus_rdata <= {{(BUS_W-CW){1'b0}}, ae_thr};
                default:   bus_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_req,
    input logic          bus_we,
    input logic          bus_win,
    input logic [4:0]    bus_addr,
    input logic [CW-1:0] level,
    input logic [5:0]    events,
    input logic [5:0]    ie,
    input logic          irq
);
    logic d_wr, d_rd, ev_wr;
    assign d_wr  = bus_req &&  bus_we && !bus_win && bus_addr == 5'h00;
    assign d_rd  = bus_req && !bus_we && !bus_win && bus_addr == 5'h00;
    assign ev_wr = bus_req &&  bus_we &&  bus_win && bus_addr == 5'h08;

    // R4
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        level <= CW'(DEPTH));

    // R4
    level_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (level == $past(level) || level == $past(level) + 1'b1
                  || level + 1'b1 == $past(level)));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (d_wr && level == CW'(DEPTH)) |=> (level == CW'(DEPTH) && events[4]));

    // R7
    underflow_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (d_rd && level == '0) |=> (level == '0 && events[5]));

    // R8
    sticky_evt_chk: assert property (@(posedge clk) disable iff (rst)
        !ev_wr |=> ((events & $past(events)) == $past(events)));

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((events & ie) == 6'd0) |-> !irq);

endmodule

bind pkt_fifo_csr pfc_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_win  (bus_win),
    .bus_addr (bus_addr),
    .level    (level),
    .events   (ev_bits),
    .ie       (ie_bits),
    .irq      (irq)
);

// File: tb/pkt_fifo_csr_test.sv
module pkt_fifo_csr_test;
    localparam int DEPTH = 16;
    localparam int AFI   = DEPTH - 4;
    localparam int AEI   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0, bus_we = 1'b0, bus_win = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    logic [31:0] got;

    always #4 clk = ~clk;   // 125 MHz

    pkt_fifo_csr #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_win(bus_win), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic win, input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_win = win; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic win, input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_win = win; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] stat_exp(int lvl, int af, int ae);
        return {26'd0, 1'b0, 1'b0, lvl <= ae, lvl >= af, lvl == 0, lvl == DEPTH};
    endfunction

    function automatic logic [31:0] meta_exp(int k);
        logic [7:0] e = 8'(k) ^ 8'h3C;
        return {8'h00, e, 8'(k), 1'b0, 5'(k % 4), k == DEPTH, k == 1};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rd(1, 5'h00, got); check("R1 level", got, 0);
        rd(1, 5'h04, got); check("R1 status", got, 32'h0A);
        rd(1, 5'h08, got); check("R1 events", got, 0);
        rd(1, 5'h0C, got); check("R1 enable", got, 0);
        rd(1, 5'h10, got); check("R1 af thr", got, AFI);
        rd(1, 5'h14, got); check("R1 ae thr", got, AEI);
        check("R1 irq", {31'd0, irq}, 0);

        // fill: R2, R3 (reserved bits written as ones), R4, R5
        for (int k = 1; k <= DEPTH; k++) begin
            wr(0, 5'h04, meta_exp(k) | 32'hFF00_0080);
            wr(0, 5'h00, 32'hD000_0000 + 32'(k * 257));
            rd(1, 5'h00, got); check("R4 level fill", got, k);
            rd(1, 5'h04, got); check("R4 R5 status fill", got, stat_exp(k, AFI, AEI));
        end
        idle(2);
        // R8 only rises of afull and full
        rd(1, 5'h08, got); check("R8 events after fill", got, 32'h05);

        // R6 overflow
        wr(0, 5'h00, 32'hDEAD_BEEF);
        idle(2);
        rd(1, 5'h00, got); check("R6 level held", got, DEPTH);
        rd(1, 5'h08, got); check("R6 overflow event", got, 32'h15);

        // R9 selective clear; full persists but no new rise
        wr(1, 5'h08, 32'h01);
        idle(2);
        rd(1, 5'h08, got); check("R9 clear full only", got, 32'h14);

        // R10
        wr(1, 5'h0C, 32'h10);
        check("R10 irq enabled", {31'd0, irq}, 1);
        wr(1, 5'h0C, 32'h08);
        check("R10 irq masked", {31'd0, irq}, 0);

        // drain: R2 order, R3 metadata of the same entry
        for (int k = 1; k <= DEPTH; k++) begin
            rd(0, 5'h00, got); check("R2 data order", got, 32'hD000_0000 + 32'(k * 257));
            rd(0, 5'h04, got); check("R3 metadata", got, meta_exp(k));
            rd(1, 5'h04, got); check("R4 R5 status drain", got, stat_exp(DEPTH - k, AFI, AEI));
        end
        idle(2);
        rd(1, 5'h08, got); check("R8 events after drain", got, 32'h1E);
        check("R10 irq aempty", {31'd0, irq}, 1);

        // R7 underflow
        rd(0, 5'h00, got); check("R7 underflow data", got, 0);
        idle(2);
        rd(1, 5'h00, got); check("R7 level zero", got, 0);
        rd(1, 5'h08, got); check("R7 underflow event", got, 32'h3E);

        // R9 clear all; conditions still true but no rise
        wr(1, 5'h08, 32'h3F);
        idle(3);
        rd(1, 5'h08, got); check("R9 clear all", got, 0);
        check("R10 irq idle", {31'd0, irq}, 0);

        // R5 threshold sweep at level 3
        for (int k = 0; k < 3; k++) wr(0, 5'h00, 32'(k));
        for (int t = 0; t <= DEPTH; t++) begin
            wr(1, 5'h10, 32'(t));
            wr(1, 5'h14, 32'(t));
            rd(1, 5'h10, got); check("R5 af readback", got, t);
            rd(1, 5'h04, got); check("R5 thr sweep", got, stat_exp(3, t, t));
        end

        // R8 rise of almost-full when threshold drops under level
        wr(1, 5'h08, 32'h3F);
        wr(1, 5'h10, 32'd10);
        idle(2);
        wr(1, 5'h08, 32'h3F);
        idle(2);
        wr(1, 5'h10, 32'd2);
        idle(2);
        rd(1, 5'h08, got); check("R8 afull rise by threshold", got, 32'h04);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule